// File: doc/BRIEF.md
# Write-Masked GPIO Register Bank

This block is a 32-pin general-purpose I/O controller on a plain 32-bit register bus. Software sets the output level and the direction of any pin with a single write. It never has to read a register, change one bit and write the whole word back.

The output values and the directions are each kept as two 16-bit halves. A write to either half carries a per-bit enable mask in its upper 16 bits and the new values in its lower 16 bits. Only the bits whose enable is set are updated.

The block drives each pin's output value and output enable. It passes the pin input levels through a two-flop synchronizer, and a read at one address returns all 32 synchronized levels. A fixed identifier at another address lets software recognise this register layout.

Top module: `gpio_wm_bank`

## Requirements
- R1: After reset every output-data bit and every direction bit is 0, so `pin_out` and `pin_oe` are 0 and all four control registers read back as 0.
- R2: On a write to a control register, data bit k (0..15) takes `wdata[k]` when the enable bit `wdata[16+k]` is 1.
- R3: On a write to a control register, data bits whose enable bit is 0 keep their previous value, and a write with an all-zero enable mask changes nothing.
- R4: The output-data low half is at offset 0x00 and drives pins 0–15. The high half is at offset 0x04 and drives pins 16–31, so the register holding pin n is at (n>>4)<<2.
- R5: The direction low half is at offset 0x08 and the high half is at offset 0x0C, with the same pin mapping. A 1 makes the pin an output (`pin_oe` bit set) and a 0 makes it an input.
- R6: A read of a control register returns its 16 stored bits in `rdata[15:0]`, with `rdata[31:16]` equal to 0.
- R7: A read of offset 0x70 returns the synchronized level of pin n in bit n. A level change applied just before clock edge e1 is returned by a read whose enable is sampled at edge e3, and not by one sampled at edge e2 or earlier.
- R8: A read of offset 0x78 returns the constant 0x0101157C.
- R9: Reads of any other offset return 0. Writes to any other offset leave `pin_out`, `pin_oe` and every register unchanged.
- R10: A write that enables a single pin changes only that pin's output or direction bit. Every other pin's output and direction stay as they were.
- R11: Read data is registered. `bus_rdata` holds the value selected by the read sampled at the previous clock edge and is 0 in the cycle after any edge where `bus_re` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: [31:16] per-bit enables, [15:0] values |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Driven level per pin |
| pin_oe | output | 32 | Output enable per pin |

## Verification
The bench sends writes with partial and empty enable masks. A design that treated the mask as ignored, or cleared the unmasked bits, would corrupt neighbouring pins, and the checks on `pin_out` and `pin_oe` after each write report this. It also writes to the high halves and to unmapped offsets, which catches swapped halves, a missing +4 offset or decoding that aliases the high byte-address bits.

The synchronizer latency is measured cycle by cycle with a continuous read of the pin-level offset. A design with one stage too few or one too many returns the new level one read early or one read late. Reads of the identifier and of unmapped offsets, together with the check that read data is 0 when no read is in progress, catch leaking upper bits and read data that is not cleared.

// File: rtl/gpio_wm_pkg.sv
package gpio_wm_pkg;
    localparam int unsigned PIN_CNT  = 32;
    localparam int unsigned HALF_W   = 16;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned HALVES   = PIN_CNT / HALF_W;
    // output-data halves first, then direction halves, each 4 bytes apart
    localparam int unsigned CTRL_REGS = 2 * HALVES;
    localparam logic [7:0] OFS_LEVELS  = 8'h70;
    localparam logic [7:0] OFS_IDENT   = 8'h78;
    localparam logic [WORD_W-1:0] IDENT_VALUE = 32'h0101_157C;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_state_t;
endpackage

// File: rtl/gpio_wm_half_reg.sv
module gpio_wm_half_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } half_t;

    half_t half_d, half_q;

    always_comb begin
        half_d = half_q;
        if (wr_en) begin
            half_d.bits = (half_q.bits & ~wr_mask) | (wr_val & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= '0;
        else        half_q <= half_d;
    end

    assign q = half_q.bits;
endmodule

// File: rtl/gpio_wm_sync.sv
module gpio_wm_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_wm_bank.sv
module gpio_wm_bank
    import gpio_wm_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_oe
);
    logic [CTRL_REGS-1:0] hit;
    logic [HALF_W-1:0]    ctrl_q [CTRL_REGS];
    logic [PIN_CNT-1:0]   levels;

    // one masked half register per control offset
    for (genvar i = 0; i < CTRL_REGS; i++) begin : g_ctrl
        assign hit[i] = (bus_addr == ADDR_W'(i * 4));

        gpio_wm_half_reg #(.W(HALF_W)) u_half (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we && hit[i]),
            .wr_mask (bus_wdata[WORD_W-1:HALF_W]),
            .wr_val  (bus_wdata[HALF_W-1:0]),
            .q       (ctrl_q[i])
        );
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_pins
        assign pin_out[h*HALF_W +: HALF_W] = ctrl_q[h];
        assign pin_oe [h*HALF_W +: HALF_W] = ctrl_q[HALVES + h];
    end

    gpio_wm_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (levels)
    );

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (bus_re) begin
            for (int k = 0; k < CTRL_REGS; k++) begin
                if (hit[k]) rd_d.rdata = {{(WORD_W-HALF_W){1'b0}}, ctrl_q[k]};
            end
            if (bus_addr == ADDR_W'(OFS_LEVELS)) rd_d.rdata = levels;
            if (bus_addr == ADDR_W'(OFS_IDENT))  rd_d.rdata = IDENT_VALUE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
endmodule

// File: rtl/gpio_wm_chk.sv
module gpio_wm_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       pin_out,
    input logic [31:0]       pin_oe
);
    logic ctrl_ofs;
    assign ctrl_ofs = (bus_addr == ADDR_W'(8'h00)) || (bus_addr == ADDR_W'(8'h04)) ||
                      (bus_addr == ADDR_W'(8'h08)) || (bus_addr == ADDR_W'(8'h0C));

    // R2
    masked_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h00)) |=>
        pin_out[15:0] == (($past(pin_out[15:0]) & ~$past(bus_wdata[31:16])) |
                          ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

    // R4
    high_half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h04)) |=> ($stable(pin_out[15:0]) && $stable(pin_oe)));

    // R10
    low_half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h00)) |=> ($stable(pin_out[31:16]) && $stable(pin_oe)));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && ctrl_ofs) |=> bus_rdata[31:16] == 16'h0);

    // R8
    ident_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(8'h78)) |=> bus_rdata == 32'h0101_157C);

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !ctrl_ofs) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R11
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> bus_rdata == 32'h0);
endmodule

bind gpio_wm_bank gpio_wm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_wm_bank_test.sv
module gpio_wm_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    logic rd_seen = 1'b0;

    always #10 clk = ~clk;

    gpio_wm_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always @(posedge clk) rd_seen <= bus_re;

    // monitor: compares registered read data against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rd_seen) begin
                item_t it;
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s rdata actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end else if (bus_rdata !== 32'h0) begin
                errors++;
                $display("FAIL R11 idle rdata actual %h expected 00000000", bus_rdata);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b0;
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b1;
        bus_addr = a;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd_chg(input logic [31:0] lvl, input logic [31:0] e, input string tag);
        rd(8'h70, e, tag);
        pin_in = lvl;
    endtask

    task automatic chk_pins(input logic [31:0] eo, input logic [31:0] ee, input string tag);
        idle();
        checks++;
        if (pin_out !== eo || pin_oe !== ee) begin
            errors++;
            $display("FAIL %s pins actual out %h oe %h expected out %h oe %h",
                     tag, pin_out, pin_oe, eo, ee);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_pins(32'h0, 32'h0, "R1");
        rd(8'h00, 32'h0, "R1 data lo");
        rd(8'h04, 32'h0, "R1 data hi");
        rd(8'h08, 32'h0, "R1 dir lo");
        rd(8'h0C, 32'h0, "R1 dir hi");
        // R2 R4 full-mask low write
        wr(8'h00, 32'hFFFF_A5C3);
        chk_pins(32'h0000_A5C3, 32'h0, "R2 R4 low full mask");
        // R3 partial mask clears only enabled bits
        wr(8'h00, 32'h00F0_0000);
        chk_pins(32'h0000_A503, 32'h0, "R3 partial mask");
        // R3 empty mask changes nothing
        wr(8'h00, 32'h0000_FFFF);
        chk_pins(32'h0000_A503, 32'h0, "R3 empty mask");
        // R4 high half drives pins 16-31
        wr(8'h04, 32'h8001_FFFF);
        chk_pins(32'h8001_A503, 32'h0, "R4 high half");
        // R5 direction halves
        wr(8'h08, 32'h0003_0001);
        wr(8'h0C, 32'hFFFF_1234);
        chk_pins(32'h8001_A503, 32'h1234_0001, "R5 direction");
        // R10 single-pin writes
        wr(8'h00, 32'h0004_0004);
        chk_pins(32'h8001_A507, 32'h1234_0001, "R10 set pin 2");
        wr(8'h0C, 32'h0010_0000);
        chk_pins(32'h8001_A507, 32'h1224_0001, "R10 clear dir pin 20");
        // R6 readback
        rd(8'h00, 32'h0000_A507, "R6 data lo");
        rd(8'h04, 32'h0000_8001, "R6 data hi");
        rd(8'h08, 32'h0000_0001, "R6 dir lo");
        rd(8'h0C, 32'h0000_1224, "R6 dir hi");
        idle();
        // R8 identifier
        rd(8'h78, 32'h0101_157C, "R8 ident");
        // R9 unmapped offsets
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h74, 32'hFFFF_0000);
        wr(8'h80, 32'hFFFF_FFFF);
        chk_pins(32'h8001_A507, 32'h1224_0001, "R9 unmapped writes");
        rd(8'h10, 32'h0, "R9 read 0x10");
        rd(8'h7C, 32'h0, "R9 read 0x7C");
        rd(8'h80, 32'h0, "R9 read 0x80");
        rd(8'h00, 32'h0000_A507, "R9 data lo intact");
        idle();
        // R7 synchronized pin levels and latency
        pin_in = 32'h1357_9BDF;
        repeat (4) idle();
        rd(8'h70, 32'h1357_9BDF, "R7 levels");
        rd_chg(32'hCAFE_0001, 32'h1357_9BDF, "R7 latency edge1");
        rd(8'h70, 32'h1357_9BDF, "R7 latency edge2");
        rd(8'h70, 32'hCAFE_0001, "R7 latency edge3");
        idle();
        // R11 idle cycles checked by monitor
        repeat (4) idle();
        done = 1'b1;
        if (sb.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL R11 pending reads actual %0d expected 0", sb.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule